// File: doc/BRIEF.md
# NAND Bus Timing Strobe Generator

This block drives the control strobes of an 8-bit NAND flash bus: chip enable, write enable, read enable, command latch and address latch. It runs one bus cycle at a time: a command, address, data-write or data-read cycle. Every phase of that cycle lasts a number of system clocks taken from its own field of a packed timing word. A small register write port holds the timing word, the interface setup bits and a lock. The lock must be opened with a key value before any configuration register can change, and it closes again after every such write.

A sequencer above this block presents one request at a time on a valid/ready handshake. The block then steps through the chip-enable setup, the active strobe phase, the recovery phase and, for reads, a bus turnaround. For a request flagged as one that makes the flash busy, it then waits a programmable delay before it watches the synchronized ready/busy pin, so that a busy indication which arrives late is still seen. It pulses a done flag when the cycle is complete. Read data is captured on the rising edge of read enable.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset the strobes are inactive (nand_ce_n, nand_we_n and nand_re_n high, nand_cle, nand_ale and nand_dq_oe low), req_ready is 1, cfg_timing is 26'h3FFFFFF, cfg_large_page and cfg_four_addr are 0, cfg_ce_normal is 1 and the lock is closed.
- R2: Register addresses are 0 for the lock, 1 for timing, 2 for interface setup and 3 for chip-enable control. A write to address 0 of exactly 32'h0000A25E opens the lock, and a write of any other value to address 0 closes it. A write to addresses 1 to 3 while the lock is closed leaves every cfg output unchanged.
- R3: Any write to address 1, 2 or 3 closes the lock again, so a second protected write without a new key is ignored.
- R4: The timing word holds the write-low count in bits 3:0, write-high in 7:4, read-low in 11:8, read-high in 15:12, turnaround in 18:16, busy delay in 23:19 and chip-enable setup in 25:24. It is shown on cfg_timing.
- R5: A request of kind 0 (command), 1 (address) or 2 (data write) holds nand_ce_n low for setup+1 clocks. It then holds nand_we_n low for write-low+1 clocks and high for write-high+1 clocks. nand_cle is high only for kind 0 and nand_ale only for kind 1, and nand_dq_oe is high with nand_dq_out equal to req_data.
- R6: A request of kind 3 (data read) holds nand_re_n low for read-low+1 clocks and high for read-high+1 clocks, followed by turnaround+1 clocks. nand_dq_oe stays low, and rd_data takes the value nand_dq_in had at the clock edge where nand_re_n rises.
- R7: A request is accepted only while req_ready is 1. req_ready stays 0 until the cycle ends, and req_done is then high for exactly one clock.
- R8: A request with req_wait_busy set first counts busy-delay+1 clocks after the strobe phases. It then waits until nand_rb_n (1 = ready), passed through a two-stage synchronizer, reads high. req_done never comes while the synchronized pin reads busy.
- R9: Interface setup bit 2 drives cfg_large_page and bit 1 drives cfg_four_addr. Chip-enable control bit 0 drives cfg_ce_normal. When that bit is 0, nand_ce_n is held low even while the bus is idle.
- R10: stat bit 1 is controller ready (equal to req_ready) and stat bit 0 is the synchronized flash ready level.
- R11: nand_we_n and nand_re_n are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Bus cycle request |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | 8 | Byte driven for write-type cycles |
| req_wait_busy | input | 1 | Wait for flash ready after this cycle |
| req_ready | output | 1 | Block idle, request may be given |
| req_done | output | 1 | One-clock pulse at end of cycle |
| rd_data | output | 8 | Byte captured by the last read cycle |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |
| stat | output | 2 | Bit 1 controller ready, bit 0 flash ready |
| cfg_timing | output | 26 | Current timing word |
| cfg_large_page | output | 1 | Large-page mode select |
| cfg_four_addr | output | 1 | Four address cycles select |
| cfg_ce_normal | output | 1 | Normal chip-enable behaviour |

## Verification
The assertions assume that req_valid is raised only while req_ready is high and stays up for a single accepting clock. They also assume that nand_dq_in and nand_rb_n change away from the rising clock edge. The bench drives every input on the falling edge and drops req_valid right after acceptance. It raises the flash busy level only some clocks after write enable rises, and it programs a busy delay long enough that this late busy is caught, which matches the timing contract the busy wait relies on.

// File: rtl/nstb_pkg.sv
package nstb_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WDATA = 2'd2,
        KIND_RDATA = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_TURN,
        PH_BDLY,
        PH_BWAIT
    } phase_e;

    // Packed most significant field first; positions are decoded by software.
    typedef struct packed {
        logic [1:0] cea;
        logic [4:0] bsy;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } timing_t;

    localparam int TIMING_W = $bits(timing_t);
    localparam int CNT_W    = 5;

    localparam logic [1:0] REGA_LOCK   = 2'd0;
    localparam logic [1:0] REGA_TIMING = 2'd1;
    localparam logic [1:0] REGA_IFACE  = 2'd2;
    localparam logic [1:0] REGA_CE     = 2'd3;

endpackage

// File: rtl/nstb_cfg_regs.sv
module nstb_cfg_regs
    import nstb_pkg::*;
#(
    parameter int WDATA_W  = 32,
    parameter int LOCK_KEY = 32'h0000_A25E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [WDATA_W-1:0] wr_data,
    output timing_t            timing,
    output logic               large_page,
    output logic               four_addr,
    output logic               ce_normal
);

    typedef struct packed {
        timing_t timing;
        logic    large_page;
        logic    four_addr;
        logic    ce_normal;
        logic    unlocked;
    } cfg_state_t;

    localparam logic [WDATA_W-1:0] KEY_VAL = WDATA_W'(LOCK_KEY);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == REGA_LOCK) begin
                st_d.unlocked = (wr_data == KEY_VAL);
            end else begin
                if (st_q.unlocked) begin
                    case (wr_addr)
                        REGA_TIMING: st_d.timing = timing_t'(wr_data[TIMING_W-1:0]);
                        REGA_IFACE: begin
                            st_d.large_page = wr_data[2];
                            st_d.four_addr  = wr_data[1];
                        end
                        default:     st_d.ce_normal = wr_data[0];
                    endcase
                end
                st_d.unlocked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.timing     <= '1;
            st_q.large_page <= 1'b0;
            st_q.four_addr  <= 1'b0;
            st_q.ce_normal  <= 1'b1;
            st_q.unlocked   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timing     = st_q.timing;
    assign large_page = st_q.large_page;
    assign four_addr  = st_q.four_addr;
    assign ce_normal  = st_q.ce_normal;

    // R2: while closed, configuration cannot move in the next cycle
    assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.unlocked |=> ($stable(st_q.timing) && $stable(st_q.ce_normal)
                            && $stable(st_q.large_page) && $stable(st_q.four_addr)));

    // R3: a protected write always leaves the lock closed
    assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != REGA_LOCK) |=> !st_q.unlocked);

endmodule

// File: rtl/nstb_strobe_fsm.sv
module nstb_strobe_fsm
    import nstb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  timing_t           timing,
    input  logic              ce_normal,
    input  logic              req_valid,
    input  req_kind_e         req_kind,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_wait_busy,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              cle,
    output logic              ale,
    output logic              ce_n,
    output logic              we_n,
    output logic              re_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              rb_n,
    output logic              nand_ready
);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        req_kind_e         kind;
        logic [DATA_W-1:0] wdata;
        logic              wait_busy;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              cle;
        logic              ale;
        logic              ce_n;
        logic              we_n;
        logic              re_n;
        logic              dq_oe;
    } fsm_state_t;

    fsm_state_t st_d, st_q;

    // ready/busy synchronizer
    logic [SYNC_STAGES-1:0] rb_sync_q;
    logic                   rb_ok;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rb_sync_q <= '1;
                else        rb_sync_q <= rb_n;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rb_sync_q <= '1;
                else        rb_sync_q <= {rb_sync_q[SYNC_STAGES-2:0], rb_n};
            end
        end
    endgenerate

    assign rb_ok = rb_sync_q[SYNC_STAGES-1];

    logic cnt_zero;
    logic is_rd;
    logic strobe_end;
    logic bus_phase;
    logic rd_next;

    assign cnt_zero = (st_q.cnt == '0);
    assign is_rd    = (st_q.kind == KIND_RDATA);

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        strobe_end = 1'b0;

        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase     = PH_SETUP;
                    st_d.cnt       = CNT_W'(timing.cea);
                    st_d.kind      = req_kind;
                    st_d.wdata     = req_data;
                    st_d.wait_busy = req_wait_busy;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    st_d.phase = PH_LOW;
                    st_d.cnt   = is_rd ? CNT_W'(timing.rd_lo) : CNT_W'(timing.wr_lo);
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_LOW: begin
                if (cnt_zero) begin
                    st_d.phase = PH_HIGH;
                    st_d.cnt   = is_rd ? CNT_W'(timing.rd_hi) : CNT_W'(timing.wr_hi);
                    if (is_rd) begin
                        st_d.rdata = dq_in;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (cnt_zero) begin
                    if (is_rd) begin
                        st_d.phase = PH_TURN;
                        st_d.cnt   = CNT_W'(timing.turn);
                    end else begin
                        strobe_end = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_TURN: begin
                if (cnt_zero) strobe_end = 1'b1;
                else          st_d.cnt   = st_q.cnt - 1'b1;
            end
            PH_BDLY: begin
                if (cnt_zero) st_d.phase = PH_BWAIT;
                else          st_d.cnt   = st_q.cnt - 1'b1;
            end
            PH_BWAIT: begin
                if (rb_ok) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        if (strobe_end) begin
            if (st_q.wait_busy) begin
                st_d.phase = PH_BDLY;
                st_d.cnt   = CNT_W'(timing.bsy);
            end else begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
        end

        // Pin values registered from the phase being entered
        bus_phase  = (st_d.phase == PH_SETUP) || (st_d.phase == PH_LOW) ||
                     (st_d.phase == PH_HIGH);
        rd_next    = (st_d.kind == KIND_RDATA);
        st_d.cle   = bus_phase && (st_d.kind == KIND_CMD);
        st_d.ale   = bus_phase && (st_d.kind == KIND_ADDR);
        st_d.dq_oe = bus_phase && !rd_next;
        st_d.we_n  = !((st_d.phase == PH_LOW) && !rd_next);
        st_d.re_n  = !((st_d.phase == PH_LOW) && rd_next);
        st_d.ce_n  = ce_normal ? (st_d.phase == PH_IDLE) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase     <= PH_IDLE;
            st_q.cnt       <= '0;
            st_q.kind      <= KIND_CMD;
            st_q.wdata     <= '0;
            st_q.wait_busy <= 1'b0;
            st_q.rdata     <= '0;
            st_q.done      <= 1'b0;
            st_q.cle       <= 1'b0;
            st_q.ale       <= 1'b0;
            st_q.ce_n      <= 1'b1;
            st_q.we_n      <= 1'b1;
            st_q.re_n      <= 1'b1;
            st_q.dq_oe     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.phase == PH_IDLE);
    assign done       = st_q.done;
    assign rd_data    = st_q.rdata;
    assign cle        = st_q.cle;
    assign ale        = st_q.ale;
    assign ce_n       = st_q.ce_n;
    assign we_n       = st_q.we_n;
    assign re_n       = st_q.re_n;
    assign dq_out     = st_q.wdata;
    assign dq_oe      = st_q.dq_oe;
    assign nand_ready = rb_ok;

    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    assert_we_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_blocks_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BWAIT && !rb_ok) |=> !done);

    assert_read_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> (rd_data == $past(dq_in)));

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
    import nstb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WDATA_W     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_KEY    = 32'h0000_A25E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [WDATA_W-1:0] reg_wdata,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [DATA_W-1:0]  req_data,
    input  logic               req_wait_busy,
    output logic               req_ready,
    output logic               req_done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_ce_n,
    output logic               nand_we_n,
    output logic               nand_re_n,
    output logic [DATA_W-1:0]  nand_dq_out,
    output logic               nand_dq_oe,
    input  logic [DATA_W-1:0]  nand_dq_in,
    input  logic               nand_rb_n,
    output logic [1:0]         stat,
    output logic [TIMING_W-1:0] cfg_timing,
    output logic               cfg_large_page,
    output logic               cfg_four_addr,
    output logic               cfg_ce_normal
);

    timing_t timing_w;
    logic    nand_ready_w;

    nstb_cfg_regs #(
        .WDATA_W  (WDATA_W),
        .LOCK_KEY (LOCK_KEY)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .timing     (timing_w),
        .large_page (cfg_large_page),
        .four_addr  (cfg_four_addr),
        .ce_normal  (cfg_ce_normal)
    );

    nstb_strobe_fsm #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .timing        (timing_w),
        .ce_normal     (cfg_ce_normal),
        .req_valid     (req_valid),
        .req_kind      (req_kind_e'(req_kind)),
        .req_data      (req_data),
        .req_wait_busy (req_wait_busy),
        .req_ready     (req_ready),
        .done          (req_done),
        .rd_data       (rd_data),
        .cle           (nand_cle),
        .ale           (nand_ale),
        .ce_n          (nand_ce_n),
        .we_n          (nand_we_n),
        .re_n          (nand_re_n),
        .dq_out        (nand_dq_out),
        .dq_oe         (nand_dq_oe),
        .dq_in         (nand_dq_in),
        .rb_n          (nand_rb_n),
        .nand_ready    (nand_ready_w)
    );

    assign cfg_timing = timing_w;
    assign stat       = {req_ready, nand_ready_w};

endmodule

// File: tb/nand_strobe_gen_bench.sv
module nand_strobe_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [7:0]  req_data = 8'd0;
    logic        req_wait_busy = 1'b0;
    logic        req_ready, req_done;
    logic [7:0]  rd_data;
    logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n;
    logic [7:0]  nand_dq_out;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_in = 8'd0;
    logic        nand_rb_n = 1'b1;
    logic [1:0]  stat;
    logic [25:0] cfg_timing;
    logic        cfg_large_page, cfg_four_addr, cfg_ce_normal;

    int checks = 0;
    int errors = 0;

    int t_c, t_wl, t_wh, t_rl, t_rh, t_ta, t_bd;

    always #5 clk = ~clk;

    nand_strobe_gen u_nand_strobe_gen (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
        .req_wait_busy(req_wait_busy), .req_ready(req_ready), .req_done(req_done),
        .rd_data(rd_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
        .nand_rb_n(nand_rb_n), .stat(stat), .cfg_timing(cfg_timing),
        .cfg_large_page(cfg_large_page), .cfg_four_addr(cfg_four_addr),
        .cfg_ce_normal(cfg_ce_normal)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_timing(input int c, input int wl, input int wh,
                                                input int rl, input int rh, input int ta,
                                                input int bd);
        return (32'(c) << 24) | (32'(bd) << 19) | (32'(ta) << 16) | (32'(rh) << 12) |
               (32'(rl) << 8) | (32'(wh) << 4) | 32'(wl);
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_timing(input int c, input int wl, input int wh, input int rl,
                              input int rh, input int ta, input int bd);
        t_c = c; t_wl = wl; t_wh = wh; t_rl = rl; t_rh = rh; t_ta = ta; t_bd = bd;
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd1, pack_timing(c, wl, wh, rl, rh, ta, bd));
    endtask

    // Issues one request and measures it at falling edges.
    task automatic run_req(input logic [1:0] kind, input logic [7:0] data, input bit busy,
                           input string tag);
        int k = 0, we_lo = 0, re_lo = 0, ce_lo = 0, exp_lat;
        bit cle_s = 0, ale_s = 0, oe_bad = 0, both = 0, got = 0, ready_bad = 0, prev_re = 1;
        exp_lat = (t_c + 1) + ((kind == 2'd3) ? (t_rl + 1 + t_rh + 1 + t_ta + 1)
                                              : (t_wl + 1 + t_wh + 1))
                  + (busy ? (t_bd + 2) : 0) + 1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_data = data; req_wait_busy = busy;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got && k < 200) begin
            k++;
            if (!nand_we_n) we_lo++;
            if (!nand_re_n) re_lo++;
            if (!nand_ce_n) ce_lo++;
            if (nand_cle) cle_s = 1;
            if (nand_ale) ale_s = 1;
            if (nand_dq_oe && nand_dq_out != data) oe_bad = 1;
            if (nand_dq_oe && kind == 2'd3) oe_bad = 1;
            if (!nand_we_n && !nand_re_n) both = 1;
            if (req_done) got = 1;
            else if (req_ready || stat[1]) ready_bad = 1;
            if (!prev_re && nand_re_n) nand_dq_in = ~nand_dq_in;
            prev_re = nand_re_n;
            if (!got) @(negedge clk);
        end
        check(k == exp_lat, {tag, " R7 latency"}, k, exp_lat);
        check(!ready_bad, {tag, " R7/R10 ready low while active"}, ready_bad, 0);
        check(!both, {tag, " R11 strobes exclusive"}, both, 0);
        check(ce_lo == exp_lat - 1, {tag, " R5 ce low length"}, ce_lo, exp_lat - 1);
        check(!oe_bad, {tag, " R5/R6 data drive"}, oe_bad, 0);
        if (kind == 2'd3) begin
            check(re_lo == t_rl + 1, {tag, " R6 re low"}, re_lo, t_rl + 1);
            check(we_lo == 0, {tag, " R6 no we"}, we_lo, 0);
        end else begin
            check(we_lo == t_wl + 1, {tag, " R5 we low"}, we_lo, t_wl + 1);
            check(re_lo == 0, {tag, " R5 no re"}, re_lo, 0);
        end
        check(cle_s == (kind == 2'd0), {tag, " R5 cle"}, cle_s, kind == 2'd0);
        check(ale_s == (kind == 2'd1), {tag, " R5 ale"}, ale_s, kind == 2'd1);
        @(negedge clk);
        check(!req_done, {tag, " R7 done single"}, req_done, 0);
    endtask

    task automatic t_reset;
        check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes high",
              {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        check(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches low",
              {nand_cle, nand_ale, nand_dq_oe}, 0);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(cfg_timing == 26'h3FFFFFF, "R1 timing reset", cfg_timing, 26'h3FFFFFF);
        check({cfg_large_page, cfg_four_addr, cfg_ce_normal} == 3'b001, "R1 cfg bits",
              {cfg_large_page, cfg_four_addr, cfg_ce_normal}, 3'b001);
        check(stat == 2'b11, "R10 idle status", stat, 2'b11);
    endtask

    task automatic t_lock;
        logic [31:0] w1;
        w1 = pack_timing(1, 2, 3, 4, 1, 2, 3);
        reg_write(2'd1, w1);
        check(cfg_timing == 26'h3FFFFFF, "R2 locked write ignored", cfg_timing, 26'h3FFFFFF);
        reg_write(2'd0, 32'h0000A25F);
        reg_write(2'd1, w1);
        check(cfg_timing == 26'h3FFFFFF, "R2 wrong key ignored", cfg_timing, 26'h3FFFFFF);
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd0, 32'h00000000);
        reg_write(2'd1, w1);
        check(cfg_timing == 26'h3FFFFFF, "R2 lock closed by other value", cfg_timing, 26'h3FFFFFF);
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd1, w1);
        check(cfg_timing == w1[25:0], "R2 R4 keyed write", cfg_timing, w1[25:0]);
        reg_write(2'd1, 32'h0);
        check(cfg_timing == w1[25:0], "R3 relocked", cfg_timing, w1[25:0]);
        reg_write(2'd2, 32'h6);
        check({cfg_large_page, cfg_four_addr} == 2'b00, "R3 iface relocked",
              {cfg_large_page, cfg_four_addr}, 0);
        t_c = 1; t_wl = 2; t_wh = 3; t_rl = 4; t_rh = 1; t_ta = 2; t_bd = 3;
    endtask

    task automatic t_cycles;
        run_req(2'd0, 8'h70, 1'b0, "cmd");
        run_req(2'd1, 8'h12, 1'b0, "addr");
        run_req(2'd2, 8'hC3, 1'b0, "wdata");
        nand_dq_in = 8'h5A;
        run_req(2'd3, 8'h00, 1'b0, "rdata");
        check(rd_data == 8'h5A, "R6 read capture", rd_data, 8'h5A);
        set_timing(0, 0, 1, 2, 0, 0, 1);
        run_req(2'd2, 8'h81, 1'b0, "wdata2 R4");
        nand_dq_in = 8'hA7;
        run_req(2'd3, 8'h00, 1'b0, "rdata2 R4");
        check(rd_data == 8'hA7, "R6 read capture 2", rd_data, 8'hA7);
        set_timing(3, 15, 9, 15, 15, 7, 2);
        run_req(2'd0, 8'h30, 1'b1, "cmd busy-ready R8");
    endtask

    task automatic t_late_busy;
        int k = 0, kr = -1, kd = -1;
        bit prev_we = 1, stat_ok = 1;
        set_timing(1, 2, 3, 2, 2, 1, 12);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_data = 8'h10; req_wait_busy = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (kd < 0 && k < 300) begin
            k++;
            if (req_done) kd = k;
            if (prev_we == 0 && nand_we_n == 1) kr = k;
            prev_we = nand_we_n;
            if (kr > 0 && k == kr + 10 && stat[0] != 1'b0) stat_ok = 0;
            if (kr > 0 && k == kr + 3) nand_rb_n = 1'b0;
            if (kr > 0 && k == kr + 28) nand_rb_n = 1'b1;
            if (kd < 0) @(negedge clk);
        end
        check(kd > kr + 28, "R8 done waits for ready", kd, kr + 29);
        check(kd <= kr + 34, "R8 done after release", kd, kr + 31);
        check(stat_ok, "R10 flash busy status", stat_ok, 1);
        @(negedge clk);
        check(stat == 2'b11, "R10 status back to ready", stat, 2'b11);
    endtask

    task automatic t_iface;
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd2, 32'h4);
        check({cfg_large_page, cfg_four_addr} == 2'b10, "R9 large page bit 2",
              {cfg_large_page, cfg_four_addr}, 2'b10);
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd2, 32'h2);
        check({cfg_large_page, cfg_four_addr} == 2'b01, "R9 four addr bit 1",
              {cfg_large_page, cfg_four_addr}, 2'b01);
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd3, 32'h0);
        @(negedge clk);
        check(cfg_ce_normal == 1'b0 && nand_ce_n == 1'b0, "R9 ce forced low",
              {cfg_ce_normal, nand_ce_n}, 0);
        reg_write(2'd0, 32'h0000A25E);
        reg_write(2'd3, 32'h1);
        @(negedge clk);
        check(nand_ce_n == 1'b1, "R9 ce normal idle high", nand_ce_n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_cycles();
        t_late_busy();
        t_iface();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R7 actual=%0h expected=%0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule